// File: doc/BRIEF.md
# Two-Wire EEPROM Write-Completion Poller

After a byte or page write, a serial EEPROM spends up to about 5 ms programming its array. During that time it ignores every command and leaves its address byte unacknowledged. This controller sits on the master side of the two-wire bus and ends that wait early. It repeatedly sends a START condition followed by the device address and the direction bit for the next operation, then samples the acknowledge bit. A released (high) acknowledge means the device is still writing. The controller then sends a STOP and tries again. A low acknowledge means the write has finished. The controller then keeps SCL low without a STOP and raises `ready_o`, so a write (direction 0: word address and data follow) or a current-address read (direction 1: data follows) can continue in the same transaction.

Each bit is built from four quarter periods of `QTR_CYCLES` clocks. SDA is modelled as open drain: `sda_oe_o` high pulls the line low, and `sda_i` reads the wired line back. A cycle counter starts at the accepted trigger. If it has reached `TIMEOUT_CYCLES` when a STOP completes, the controller gives up, releases the bus and raises `fail_o`.

States:
- `ST_IDLE`: the bus is released.
- `ST_START`: START, or repeated START.
- `ST_ADDR`: eight address and direction bits.
- `ST_ACK`: the ninth clock pulse.
- `ST_STOP`: the STOP condition.
- `ST_HOLD`: acknowledged, bus held.
- `ST_FAIL`: timed out.

Transitions:
- IDLE, HOLD or FAIL go to START on an accepted trigger.
- START goes to ADDR.
- ADDR goes to ACK after the eighth bit.
- ACK goes to HOLD when the sampled acknowledge is low, and to STOP otherwise.
- STOP goes to FAIL when the timeout has expired, and back to START otherwise.

Top module: `ackpoll_ctrl`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe_o` is 0, and `ready_o` and `fail_o` are 0.
- R2: Each attempt begins with a START: SDA falls while SCL is high. It then sends the byte {address[6:0], direction bit} MSB first on eight SCL pulses. During a bit, SDA changes only while SCL is low.
- R3: On the ninth SCL pulse the controller releases SDA. It samples the line while SCL is high: low means acknowledge, high means no acknowledge.
- R4: After no acknowledge, the controller sends a STOP (SDA rises while SCL is high) and then a new START and address. For a device that refuses N attempts, it makes N+1 attempts and N STOPs, provided the timeout has not expired.
- R5: After an acknowledge, `ready_o` goes to 1, SCL stays low and SDA stays released. No STOP is sent while the bus is held.
- R6: When a STOP completes and at least `TIMEOUT_CYCLES` clocks have passed since the trigger, `fail_o` goes to 1 and the bus returns to idle (SCL and SDA high). No further attempt is made.
- R7: A trigger (`start_i` high for one clock) is accepted only in IDLE, HOLD or FAIL. The address and direction bit are latched at acceptance. A trigger during polling has no effect.
- R8: A trigger accepted in HOLD clears `ready_o` and sends a repeated START. A trigger accepted in FAIL clears `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Trigger for a polling sequence |
| dev_addr_i | input | 7 | Device address to poll |
| rw_i | input | 1 | Direction bit of the next operation (0 write, 1 read) |
| sda_i | input | 1 | Sensed level of the wired SDA line |
| scl_o | output | 1 | SCL level driven by the master |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ready_o | output | 1 | Device acknowledged, bus held |
| fail_o | output | 1 | Polling timed out |

## Verification
A bus-level device model refuses a programmed number of attempts before it acknowledges. The bench sweeps that number from zero up past the point where the timeout must win, for both direction bits and several addresses. Attempt and STOP counts and the outcome are computed from the 44-quarter attempt length.

A design that miscounts bits, changes SDA while SCL is high, or samples the acknowledge on the wrong edge shows up as a wrong decoded byte, a phantom START, or a wrong attempt count. A design that sends a STOP after an acknowledge, or keeps retrying after the timeout, is caught by the STOP counter staying open during the hold and after the failure. A trigger pulsed mid-poll with a different address catches a design that relatches its inputs while busy.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_ACK,
        ST_STOP,
        ST_HOLD,
        ST_FAIL
    } poll_state_t;

    localparam int BYTE_BITS = 8;
    localparam int QUARTERS  = 4;

endpackage

// File: rtl/ackpoll_qtick.sv
module ackpoll_qtick #(
    parameter int QTR_CYCLES = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    AST_QTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R2

endmodule

// File: rtl/ackpoll_timer.sv
module ackpoll_timer #(
    parameter int LIMIT = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q < LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q >= LIM);

    AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clr_i) |=> expired_o);  // R6

endmodule

// File: rtl/ackpoll_ctrl.sv
module ackpoll_ctrl
    import ackpoll_pkg::*;
#(
    parameter int QTR_CYCLES     = 62,
    parameter int TIMEOUT_CYCLES = 600000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [6:0] dev_addr_i,
    input  logic       rw_i,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_oe_o,
    output logic       ready_o,
    output logic       fail_o
);
    localparam int BW = $clog2(BYTE_BITS);
    localparam int QW = $clog2(QUARTERS);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_BITS - 1);
    localparam logic [QW-1:0] LAST_Q   = QW'(QUARTERS - 1);
    localparam logic [QW-1:0] SAMPLE_Q = QW'(2);

    poll_state_t          state_q, state_nxt;
    logic [QW-1:0]        q_q;
    logic [BW-1:0]        bit_q;
    logic [BYTE_BITS-1:0] byte_q;
    logic                 ack_low_q;
    logic                 tick, accept, polling, expired;

    assign accept  = start_i && (state_q == ST_IDLE || state_q == ST_HOLD ||
                                 state_q == ST_FAIL);
    assign polling = !(state_q == ST_IDLE || state_q == ST_HOLD ||
                       state_q == ST_FAIL);

    ackpoll_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (polling),
        .tick_o (tick)
    );

    ackpoll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .run_i     (polling),
        .expired_o (expired)
    );

    // Next state, taken at the end of the last quarter of a bit slot
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_START: state_nxt = ST_ADDR;
            ST_ADDR:  state_nxt = (bit_q == LAST_BIT) ? ST_ACK : ST_ADDR;
            ST_ACK:   state_nxt = ack_low_q ? ST_HOLD : ST_STOP;
            ST_STOP:  state_nxt = expired ? ST_FAIL : ST_START;
            ST_IDLE, ST_HOLD, ST_FAIL: state_nxt = state_q;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            q_q       <= '0;
            bit_q     <= '0;
            byte_q    <= '0;
            ack_low_q <= 1'b0;
        end else if (accept) begin
            state_q   <= ST_START;
            q_q       <= '0;
            bit_q     <= '0;
            byte_q    <= {dev_addr_i, rw_i};
            ack_low_q <= 1'b0;
        end else if (tick) begin
            q_q <= q_q + 1'b1;
            if (state_q == ST_ACK && q_q == SAMPLE_Q) begin
                ack_low_q <= !sda_i;
            end
            if (q_q == LAST_Q) begin
                state_q <= state_nxt;
                bit_q   <= (state_q == ST_ADDR) ? bit_q + 1'b1 : '0;
                if (state_q == ST_STOP) begin
                    ack_low_q <= 1'b0;
                end
            end
        end
    end

    // Outputs: quarter-level waveform per state
    always_comb begin
        scl_o    = 1'b1;
        sda_oe_o = 1'b0;
        ready_o  = 1'b0;
        fail_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                scl_o    = 1'b1;
                sda_oe_o = 1'b0;
            end
            ST_START: begin
                scl_o    = (q_q == 2'd1) || (q_q == 2'd2);
                sda_oe_o = q_q[1];
            end
            ST_ADDR: begin
                scl_o    = (q_q == 2'd1) || (q_q == 2'd2);
                sda_oe_o = !byte_q[LAST_BIT - bit_q];
            end
            ST_ACK: begin
                scl_o    = (q_q == 2'd1) || (q_q == 2'd2);
                sda_oe_o = 1'b0;
            end
            ST_STOP: begin
                scl_o    = (q_q != 2'd0);
                sda_oe_o = !q_q[1];
            end
            ST_HOLD: begin
                scl_o    = 1'b0;
                sda_oe_o = 1'b0;
                ready_o  = 1'b1;
            end
            ST_FAIL: begin
                scl_o    = 1'b1;
                sda_oe_o = 1'b0;
                fail_o   = 1'b1;
            end
            default: begin
                scl_o    = 1'b1;
                sda_oe_o = 1'b0;
            end
        endcase
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (scl_o && !sda_oe_o));  // R1
    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && state_q == ST_ADDR && $past(state_q == ST_ADDR))
        |-> $stable(sda_oe_o));  // R2
    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |-> !sda_oe_o);  // R3
    AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!scl_o && !sda_oe_o));  // R5
    AST_READY_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(state_q == ST_ACK && ack_low_q));  // R5
    AST_FAIL_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(expired && state_q == ST_STOP));  // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && fail_o));  // R6

endmodule

// File: tb/ackpoll_ctrl_tb.sv
module ackpoll_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 2;
    localparam int ATTEMPT    = 44 * QTR;
    localparam int TMO        = ATTEMPT * 3 + ATTEMPT / 2;
    localparam int MAX_TRIES  = TMO / ATTEMPT + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] dev_addr_i = '0;
    logic       rw_i = 1'b0;
    logic       scl_o, sda_oe_o, ready_o, fail_o;
    logic       dev_pull = 1'b0;
    wire        sda_bus = !(sda_oe_o || dev_pull);

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int stops = 0;
    int bitcnt = 9;
    int nack_n = 0;
    int bytes_seen = 0;
    int bytes_bad = 0;
    logic [7:0] shreg = '0;
    logic [7:0] exp_byte = '0;

    always #(CLK_PERIOD / 2) clk = !clk;

    ackpoll_ctrl #(.QTR_CYCLES(QTR), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dev_addr_i (dev_addr_i),
        .rw_i       (rw_i),
        .sda_i      (sda_bus),
        .scl_o      (scl_o),
        .sda_oe_o   (sda_oe_o),
        .ready_o    (ready_o),
        .fail_o     (fail_o)
    );

    // Bus-level device model
    always @(negedge sda_bus) if (scl_o) begin
        starts = starts + 1;
        bitcnt = 0;
        shreg  = '0;
    end
    always @(posedge sda_bus) if (scl_o) stops = stops + 1;
    always @(posedge scl_o) if (bitcnt < 8) begin
        shreg  = {shreg[6:0], sda_bus};
        bitcnt = bitcnt + 1;
        if (bitcnt == 8) begin
            bytes_seen = bytes_seen + 1;
            if (shreg != exp_byte) bytes_bad = bytes_bad + 1;
        end
    end
    always @(negedge scl_o) begin
        if (bitcnt == 8) begin
            bitcnt = 9;
            if (starts > nack_n) dev_pull = 1'b1;
        end else if (dev_pull) begin
            dev_pull = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic trigger(input logic [6:0] a, input logic rw);
        @(negedge clk);
        start_i    = 1'b1;
        dev_addr_i = a;
        rw_i       = rw;
        @(negedge clk);
        start_i    = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (ready_o || fail_o) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(scl_o && !sda_oe_o, "R1 bus idle", {scl_o, sda_oe_o}, 2);
        check(!ready_o && !fail_o, "R1 flags", {ready_o, fail_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int n = 0; n < 6; n++) begin
            for (int rw = 0; rw < 2; rw++) begin
                logic [6:0] a;
                logic       was_hold;
                int         exp_tries, exp_stops, s0;
                bit         exp_ok;
                a         = 7'(7'h13 * n + 7'h29 * rw + 7'h05);
                exp_ok    = (n < MAX_TRIES);
                exp_tries = exp_ok ? n + 1 : MAX_TRIES;
                exp_stops = exp_ok ? n : MAX_TRIES;
                was_hold  = ready_o;
                nack_n    = n;
                starts    = 0;
                stops     = 0;
                bytes_seen = 0;
                bytes_bad  = 0;
                exp_byte  = {a, 1'(rw)};
                trigger(a, 1'(rw));
                if (was_hold) check(!ready_o, "R8 ready cleared", ready_o, 0);
                else check(!fail_o, "R8 fail cleared", fail_o, 0);
                if (n == 2 && rw == 1) begin
                    // R7 mid-poll trigger with other inputs must be ignored
                    repeat (ATTEMPT / 2) @(negedge clk);
                    trigger(a ^ 7'h55, 1'b0);
                    dev_addr_i = 7'h00;
                end
                wait_done();
                check(ready_o == exp_ok, "R4 outcome ready", ready_o, exp_ok);
                check(fail_o == !exp_ok, "R6 outcome fail", fail_o, !exp_ok);
                check(starts == exp_tries, "R4 attempts", starts, exp_tries);
                check(stops == exp_stops, "R4 stops", stops, exp_stops);
                check(bytes_seen == exp_tries && bytes_bad == 0,
                      (n == 2 && rw == 1) ? "R7 latched byte" : "R2 address byte",
                      bytes_bad, 0);
                s0 = stops;
                repeat (3 * ATTEMPT) @(negedge clk);
                if (exp_ok) begin
                    check(ready_o && !scl_o && sda_bus, "R5 bus held",
                          {ready_o, scl_o, sda_bus}, 5);
                    check(stops == s0, "R5 no STOP while held", stops, s0);
                    check(starts == exp_tries, "R3 no retry after ack", starts, exp_tries);
                end else begin
                    check(fail_o && scl_o && sda_bus, "R6 bus idle",
                          {fail_o, scl_o, sda_bus}, 7);
                    check(starts == exp_tries, "R6 no further attempt", starts, exp_tries);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule